// File: doc/BRIEF.md
# Programmed I/O Command Decoder

This block sits between the instruction register of a small word-oriented processor and its peripheral channels. When the sequencer runs an I/O instruction, the block inspects the 18-bit instruction word. If the extension field is zero, the instruction is a standard I/O instruction, and the device field picks one of eight device channels. The block drives a one-hot select vector to that channel. It then issues up to three command pulses to the channel, one for each of three sub-cycle timing strobes. The three low bits of the word act as a mask that decides which of these pulses are emitted.

Alongside the pulses, the block returns three requests to the processor:
- a skip request, when the flag-test pulse reaches a device whose flag is up;
- a slow-cycle request, when the selected channel is one of those marked slow at build time;
- a program-interrupt request, formed from up to nine device flags.

Bit indices in this brief count from the least significant bit, so bit 0 is the LSB. There is no data stream through the block. Every pin is a plain control or status level or pulse, with no valid/ready handshake and therefore no back-pressure.

Top module: `iot_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released with all strobes low, every bit of `cmd_p1`, `cmd_p2` and `cmd_p4`, and `skip_req`, is 0.
- R2: When `iot_en` is 1 and `instr[11:9]` is 000, `dev_sel` is combinationally one-hot, with bit `instr[8:6]` set.
- R3: When `iot_en` is 0, or `instr[11:9]` is not 000, `dev_sel` and `slow_req` are 0 and no command pulse is emitted, whatever the strobes do.
- R4: A rising edge on `strobe[0]` with `instr[0]` = 1 puts a 1 on the selected device's bit of `cmd_p1` in the clock cycle that follows the edge at which the strobe is first sampled high.
- R5: In the same way, `strobe[1]` with `instr[1]` = 1 drives `cmd_p2`, and `strobe[2]` with `instr[2]` = 1 drives `cmd_p4`. Applying the strobes in the order 0, 1, 2 gives pulses in the order 1, 2, 4.
- R6: A strobe whose mask bit in `instr[2:0]` is 0 produces no pulse on its line.
- R7: Each command pulse lasts exactly one clock cycle, even when its strobe stays high for several cycles.
- R8: `skip_req` is 1 for exactly the cycle in which a `cmd_p1` pulse is emitted, and only if `dev_flag` of the selected device is 1. In all other cycles it is 0.
- R9: `slow_req` is combinationally 1 when a standard device is selected (see R2) whose bit in parameter `SLOW_MASK` is 1.
- R10: `irq_req` is combinationally 1 when any bit of `irq_flag` is 1, and 0 when all bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 18 | Instruction word (extension [11:9], device [8:6], pulse mask [2:0]) |
| iot_en | input | 1 | I/O instruction execute enable |
| strobe | input | 3 | Sub-cycle timing strobes for pulses 1, 2, 4 |
| dev_flag | input | 8 | Per-device flag tested by pulse 1 |
| irq_flag | input | 9 | Flags from devices that may request an interrupt |
| dev_sel | output | 8 | One-hot device select |
| cmd_p1 | output | 8 | Flag-test pulse per device |
| cmd_p2 | output | 8 | Clear pulse per device |
| cmd_p4 | output | 8 | Transfer-start pulse per device |
| slow_req | output | 1 | Slow-cycle request |
| skip_req | output | 1 | Skip request |
| irq_req | output | 1 | Program-interrupt request |

## Verification
The bench builds the decoder with `SLOW_MASK` = 8'hA1, so devices 0, 5 and 7 are slow. This lets the slow request be checked at both ends of the device field and at a slow channel in the middle, with fast channels between them. The word width, the eight channels and the nine interrupt flags keep their default values. With these values the bench can sweep all eight select codes, every nonzero extension pattern that blocks decoding, and every interrupt flag on its own.

// File: rtl/iot_pkg.sv
package iot_pkg;
  localparam int WORD_W  = 18;
  localparam int SEL_W   = 3;
  localparam int N_DEV   = 1 << SEL_W;
  localparam int N_PULSE = 3;
  // field positions (LSB = 0)
  localparam int EXT_LO  = 9;
  localparam int DEV_LO  = 6;
  localparam int MASK_LO = 0;
  typedef logic [N_DEV-1:0] dev_vec_t;
endpackage

// File: rtl/iot_sel_dec.sv
module iot_sel_dec
  import iot_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SEL_W,
  parameter int ND = N_DEV
) (
  input  logic [W-1:0]  instr,
  input  logic          iot_en,
  output logic          std_ok,
  output logic [ND-1:0] sel
);
  logic [SW-1:0] dev_code;
  logic [SW-1:0] ext_code;

  assign ext_code = instr[EXT_LO +: SW];
  assign dev_code = instr[DEV_LO +: SW];
  assign std_ok   = iot_en && (ext_code == '0);

  for (genvar d = 0; d < ND; d++) begin : g_sel
    assign sel[d] = std_ok && (dev_code == SW'(d));
  end
endmodule

// File: rtl/iot_pulse_gen.sv
module iot_pulse_gen #(
  parameter int ND = 8,
  parameter int NP = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          strobe,
  input  logic [NP-1:0]          mask,
  input  logic                   std_ok,
  input  logic [ND-1:0]          sel,
  input  logic [ND-1:0]          flag,
  output logic [NP-1:0][ND-1:0]  cmd,
  output logic                   skip
);
  logic [NP-1:0] strobe_q;
  logic [NP-1:0] fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= '0;
    else        strobe_q <= strobe;
  end

  assign fire = strobe & ~strobe_q & mask & {NP{std_ok}};

  for (genvar p = 0; p < NP; p++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd[p] <= '0;
      else        cmd[p] <= fire[p] ? sel : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip <= 1'b0;
    else        skip <= fire[0] && |(sel & flag);
  end
endmodule

// File: rtl/iot_req_comb.sv
module iot_req_comb #(
  parameter int ND = 8,
  parameter int NI = 9,
  parameter logic [ND-1:0] SLOW = '0
) (
  input  logic [ND-1:0] sel,
  input  logic [NI-1:0] irq_flag,
  output logic          slow_req,
  output logic          irq_req
);
  assign slow_req = |(sel & SLOW);
  assign irq_req  = |irq_flag;
endmodule

// File: rtl/iot_decoder.sv
module iot_decoder
  import iot_pkg::*;
#(
  parameter int              N_IRQ     = 9,
  parameter logic [N_DEV-1:0] SLOW_MASK = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] instr,
  input  logic              iot_en,
  input  logic [N_PULSE-1:0] strobe,
  input  logic [N_DEV-1:0]  dev_flag,
  input  logic [N_IRQ-1:0]  irq_flag,
  output logic [N_DEV-1:0]  dev_sel,
  output logic [N_DEV-1:0]  cmd_p1,
  output logic [N_DEV-1:0]  cmd_p2,
  output logic [N_DEV-1:0]  cmd_p4,
  output logic              slow_req,
  output logic              skip_req,
  output logic              irq_req
);
  logic                         std_ok;
  logic [N_PULSE-1:0][N_DEV-1:0] cmd;

  iot_sel_dec #(.W(WORD_W), .SW(SEL_W), .ND(N_DEV)) u_dec (
    .instr (instr),
    .iot_en(iot_en),
    .std_ok(std_ok),
    .sel   (dev_sel)
  );

  iot_pulse_gen #(.ND(N_DEV), .NP(N_PULSE)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .mask  (instr[MASK_LO +: N_PULSE]),
    .std_ok(std_ok),
    .sel   (dev_sel),
    .flag  (dev_flag),
    .cmd   (cmd),
    .skip  (skip_req)
  );

  iot_req_comb #(.ND(N_DEV), .NI(N_IRQ), .SLOW(SLOW_MASK)) u_req (
    .sel     (dev_sel),
    .irq_flag(irq_flag),
    .slow_req(slow_req),
    .irq_req (irq_req)
  );

  assign cmd_p1 = cmd[0];
  assign cmd_p2 = cmd[1];
  assign cmd_p4 = cmd[2];
endmodule

// File: rtl/iot_decoder_chk.sv
module iot_decoder_chk #(
  parameter int ND = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iot_en,
  input logic [ND-1:0] dev_sel,
  input logic [ND-1:0] cmd_p1,
  input logic [ND-1:0] cmd_p2,
  input logic [ND-1:0] cmd_p4,
  input logic          slow_req,
  input logic          skip_req
);
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));
  // R3
  idle_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iot_en |-> (dev_sel == '0 && !slow_req));
  // R4
  p1_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_p1) |-> $past(iot_en));
  // R5
  p_lines_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_p2) && $onehot0(cmd_p4) && $onehot0(cmd_p1));
  // R7
  p1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_p1) |=> !(|cmd_p1));
  // R7
  p2_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_p2) |=> !(|cmd_p2));
  // R7
  p4_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_p4) |=> !(|cmd_p4));
  // R8
  skip_with_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> (|cmd_p1));
endmodule

bind iot_decoder iot_decoder_chk #(.ND(iot_pkg::N_DEV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .iot_en  (iot_en),
  .dev_sel (dev_sel),
  .cmd_p1  (cmd_p1),
  .cmd_p2  (cmd_p2),
  .cmd_p4  (cmd_p4),
  .slow_req(slow_req),
  .skip_req(skip_req)
);

// File: tb/test_iot_decoder.sv
module test_iot_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] instr = '0;
  logic        iot_en = 1'b0;
  logic [2:0]  strobe = '0;
  logic [7:0]  dev_flag = '0;
  logic [8:0]  irq_flag = '0;
  logic [7:0]  dev_sel, cmd_p1, cmd_p2, cmd_p4;
  logic        slow_req, skip_req, irq_req;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  localparam logic [7:0] SLOW = 8'hA1;

  iot_decoder #(.N_IRQ(9), .SLOW_MASK(SLOW)) i_iot_decoder (
    .clk(clk), .rst_n(rst_n), .instr(instr), .iot_en(iot_en), .strobe(strobe),
    .dev_flag(dev_flag), .irq_flag(irq_flag), .dev_sel(dev_sel),
    .cmd_p1(cmd_p1), .cmd_p2(cmd_p2), .cmd_p4(cmd_p4),
    .slow_req(slow_req), .skip_req(skip_req), .irq_req(irq_req)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] mk(input int ext, input int dev, input int mask);
    return 18'((ext & 7) << 9) | 18'((dev & 7) << 6) | 18'(mask & 7);
  endfunction

  // raise strobe idx, capture outputs in the pulse cycle and in the one after
  task automatic strobe_cycle(input int idx, input int hold,
                              output logic [23:0] first, output logic [23:0] second,
                              output logic sk);
    @(negedge clk);
    strobe[idx] = 1'b1;
    @(posedge clk); #2;
    first = {cmd_p4, cmd_p2, cmd_p1};
    sk = skip_req;
    @(posedge clk); #2;
    second = {cmd_p4, cmd_p2, cmd_p1};
    for (int i = 0; i < hold; i++) @(posedge clk);
    @(negedge clk);
    strobe[idx] = 1'b0;
  endtask

  task automatic t_reset;
    #2;
    check(cmd_p1 == 0 && cmd_p2 == 0 && cmd_p4 == 0 && !skip_req, "R1 in reset",
          {cmd_p4, cmd_p2, cmd_p1}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(cmd_p1 == 0 && cmd_p2 == 0 && cmd_p4 == 0 && !skip_req, "R1 after release",
          {skip_req, cmd_p4, cmd_p2, cmd_p1}, 0);
  endtask

  task automatic t_select;
    @(negedge clk); iot_en = 1'b1;
    for (int d = 0; d < 8; d++) begin
      instr = mk(0, d, 0); #1;
      check(dev_sel == 8'(1 << d), "R2 select", dev_sel, 8'(1 << d));
      check(slow_req == SLOW[d], "R9 slow", slow_req, SLOW[d]);
    end
  endtask

  task automatic t_blocked;
    logic [23:0] a, b; logic sk;
    for (int e = 1; e < 8; e++) begin
      instr = mk(e, 5, 7); #1;
      check(dev_sel == 0 && !slow_req, "R3 ext nonzero", {slow_req, dev_sel}, 0);
    end
    instr = mk(2, 5, 7);
    strobe_cycle(0, 0, a, b, sk);
    check(a == 0, "R3 no pulse ext", a, 0);
    instr = mk(0, 7, 7); iot_en = 1'b0; #1;
    check(dev_sel == 0 && !slow_req, "R3 en low", {slow_req, dev_sel}, 0);
    strobe_cycle(2, 0, a, b, sk);
    check(a == 0, "R3 no pulse en low", a, 0);
    iot_en = 1'b1;
  endtask

  task automatic t_order;
    logic [23:0] a, b; logic sk;
    instr = mk(0, 3, 7); dev_flag = 8'h00;
    strobe_cycle(0, 0, a, b, sk);
    check(a == {16'h0, 8'h08}, "R4 p1 pulse", a, {16'h0, 8'h08});
    check(!sk, "R8 flag clear no skip", sk, 0);
    strobe_cycle(1, 0, a, b, sk);
    check(a == {8'h0, 8'h08, 8'h0}, "R5 p2 pulse", a, {8'h0, 8'h08, 8'h0});
    strobe_cycle(2, 0, a, b, sk);
    check(a == {8'h08, 16'h0}, "R5 p4 pulse", a, {8'h08, 16'h0});
    check(b == 0, "R7 p4 ends", b, 0);
  endtask

  task automatic t_mask;
    logic [23:0] a, b; logic sk;
    instr = mk(0, 6, 3'b010);
    strobe_cycle(0, 0, a, b, sk);
    check(a == 0, "R6 p1 masked", a, 0);
    strobe_cycle(1, 0, a, b, sk);
    check(a == {8'h0, 8'h40, 8'h0}, "R6 p2 enabled", a, {8'h0, 8'h40, 8'h0});
    strobe_cycle(2, 0, a, b, sk);
    check(a == 0, "R6 p4 masked", a, 0);
  endtask

  task automatic t_held;
    logic [23:0] a, b; logic sk;
    instr = mk(0, 1, 7);
    strobe_cycle(1, 4, a, b, sk);
    check(a == {8'h0, 8'h02, 8'h0}, "R7 held first", a, {8'h0, 8'h02, 8'h0});
    check(b == 0, "R7 held second", b, 0);
  endtask

  task automatic t_skip;
    logic [23:0] a, b; logic sk;
    instr = mk(0, 4, 1); dev_flag = 8'h10;
    strobe_cycle(0, 0, a, b, sk);
    check(sk == 1'b1, "R8 skip set", sk, 1);
    check(a[7:0] == 8'h10, "R8 with p1", a, 24'h10);
    #1 check(!skip_req, "R8 skip one cycle", skip_req, 0);
    dev_flag = 8'hEF;
    strobe_cycle(0, 0, a, b, sk);
    check(!sk, "R8 other flags", sk, 0);
    dev_flag = 8'h10; instr = mk(0, 4, 6);
    strobe_cycle(0, 0, a, b, sk);
    check(!sk, "R8 p1 masked no skip", sk, 0);
    dev_flag = 0;
  endtask

  task automatic t_irq;
    irq_flag = 0; #1;
    check(!irq_req, "R10 none", irq_req, 0);
    for (int i = 0; i < 9; i++) begin
      irq_flag = 9'(1 << i); #1;
      check(irq_req, "R10 single", irq_req, 1);
    end
    irq_flag = 0; #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_select;
    t_blocked;
    t_order;
    t_mask;
    t_held;
    t_skip;
    t_irq;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule